// File: doc/BRIEF.md
# Serial Input Latch Reader

This block lets a host collect a set of parallel input bits one bit per bus read. It holds two shift latches, each with its own word address on a small register bus. A write to a latch's address loads a 12-bit parallel input word into that latch. Each later read of the same address returns the next bit of that word, most significant bit first, and advances the latch. The two latches together give the host 24 input bits.

The value carried by a capture write does not matter; only the access does. After all twelve bits of a latch have been read out, further reads return zero until the host captures again. Each latch keeps its own bit count, so the host may interleave the two sequences freely.

Top module: `serial_latch_reader`

## Requirements
- R1: After synchronous reset, `bus_rdata` is 0 and `bus_rvalid` is 0. Both latches are empty, so reads before any capture return 0.
- R2: Latch 0 answers at `BASE_ADDR` (default 0x04) and latch 1 at `BASE_ADDR+2` (default 0x06). A write to any other address changes nothing. A read of any other address returns 0.
- R3: A write to a latch's address loads that latch from its parallel input (`in_word0` or `in_word1`) as sampled at that clock edge. The value of `bus_wdata` is ignored.
- R4: Every read strobe answers in the next cycle with `bus_rvalid` high for one cycle. The answer carries the latch's current bit in `bus_rdata[0]`, and bits [15:1] are always 0. The twelve bits come out MSB first: bit 11 on the first read, bit 0 on the twelfth.
- R5: Once twelve bits have been read after a capture, each further read of that latch returns 0 until the next capture write.
- R6: A capture write made partway through a sequence reloads the latch and restarts its count, so the next read returns bit 11 of the new word.
- R7: Accesses to one latch never change the contents or the count of the other latch.
- R8: If a write and a read strobe are asserted in the same cycle, the write takes effect. That read answers with `bus_rvalid` high and data 0, and it does not advance any latch.
- R9: Changes on a parallel input after its capture do not affect the bits read out from that capture.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_addr | input | 8 | Word address of the access |
| bus_wr | input | 1 | Write strobe, one cycle per access |
| bus_rd | input | 1 | Read strobe, one cycle per access |
| bus_wdata | input | 16 | Write data (ignored) |
| in_word0 | input | 12 | Parallel input for latch 0 |
| in_word1 | input | 12 | Parallel input for latch 1 |
| bus_rdata | output | 16 | Registered read data; the bit is in bit 0 |
| bus_rvalid | output | 1 | High for one cycle when read data is due |

## Verification
A capture write takes effect at the edge where its strobe is sampled. A read's answer is registered at that same edge, so it appears on `bus_rdata` and `bus_rvalid` one cycle after the strobe. The bench drives every strobe for one cycle from the falling edge. It checks the answer at the following falling edge, half a cycle after the registering edge, and compares it with a bench model of both latches that advances at the same edge. Random parallel inputs change on every access, which shows that only the value present at the capture edge is used.

// File: rtl/slr_pkg.sv
package slr_pkg;
  localparam int unsigned SLR_LANES = 2;
  localparam int unsigned SLR_ADDR_STEP = 2;

  typedef enum logic [1:0] {
    LANE_IDLE = 2'd0,
    LANE_CAP  = 2'd1,
    LANE_ADV  = 2'd2
  } lane_op_e;
endpackage

// File: rtl/slr_lane.sv
module slr_lane
  import slr_pkg::*;
#(
  parameter int unsigned WORD_W = 12
) (
  input  logic              clk,
  input  logic              rst,
  input  lane_op_e          op,
  input  logic [WORD_W-1:0] par_in,
  output logic              bit_o
);
  localparam int unsigned CW = $clog2(WORD_W + 1);
  localparam logic [CW-1:0] FULL = CW'(WORD_W);

  logic [WORD_W-1:0] shreg;
  logic [CW-1:0]     left;

  always_ff @(posedge clk) begin
    if (rst) begin
      shreg <= '0;
      left  <= '0;
    end else begin
      unique case (op)
        LANE_CAP: begin
          shreg <= par_in;
          left  <= FULL;
        end
        LANE_ADV: begin
          if (left != '0) begin
            shreg <= {shreg[WORD_W-2:0], 1'b0};
            left  <= left - 1'b1;
          end
        end
        default: ;
      endcase
    end
  end

  assign bit_o = (left != '0) ? shreg[WORD_W-1] : 1'b0;

  assert_count_range_R5: assert property (@(posedge clk) disable iff (rst)
    left <= FULL);
  assert_capture_full_R6: assert property (@(posedge clk) disable iff (rst)
    (op == LANE_CAP) |=> (left == FULL));
  assert_advance_step_R4: assert property (@(posedge clk) disable iff (rst)
    (op == LANE_ADV && left != '0) |=> (left == $past(left) - 1'b1));
  assert_exhausted_hold_R5: assert property (@(posedge clk) disable iff (rst)
    (op == LANE_ADV && left == '0) |=> (left == '0));
  assert_idle_stable_R7: assert property (@(posedge clk) disable iff (rst)
    (op == LANE_IDLE) |=> ($stable(left) && $stable(shreg)));
endmodule

// File: rtl/slr_rdmux.sv
module slr_rdmux #(
  parameter int unsigned LANES  = 2,
  parameter int unsigned DATA_W = 16
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              rd_any,
  input  logic [LANES-1:0]  rd_sel,
  input  logic [LANES-1:0]  lane_bit,
  output logic [DATA_W-1:0] rdata,
  output logic              rvalid
);
  logic picked;
  assign picked = |(rd_sel & lane_bit);

  always_ff @(posedge clk) begin
    if (rst) begin
      rdata  <= '0;
      rvalid <= 1'b0;
    end else begin
      rvalid <= rd_any;
      rdata  <= rd_any ? {{(DATA_W-1){1'b0}}, picked} : '0;
    end
  end

  assert_sel_onehot_R2: assert property (@(posedge clk) disable iff (rst)
    $onehot0(rd_sel));
  assert_rvalid_due_R4: assert property (@(posedge clk) disable iff (rst)
    rd_any |=> rvalid);
  assert_upper_zero_R4: assert property (@(posedge clk) disable iff (rst)
    rdata[DATA_W-1:1] == '0);
endmodule

// File: rtl/serial_latch_reader.sv
module serial_latch_reader
  import slr_pkg::*;
#(
  parameter int unsigned WORD_W    = 12,
  parameter int unsigned ADDR_W    = 8,
  parameter int unsigned DATA_W    = 16,
  parameter int unsigned BASE_ADDR = 4
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic              bus_wr,
  input  logic              bus_rd,
  input  logic [DATA_W-1:0] bus_wdata,
  input  logic [WORD_W-1:0] in_word0,
  input  logic [WORD_W-1:0] in_word1,
  output logic [DATA_W-1:0] bus_rdata,
  output logic              bus_rvalid
);
  localparam int unsigned LANES = SLR_LANES;

  logic [WORD_W-1:0] par_in [LANES];
  logic [LANES-1:0]  hit, rd_sel, lane_bit;
  logic              wdata_unused;

  assign par_in[0] = in_word0;
  assign par_in[1] = in_word1;
  assign wdata_unused = ^bus_wdata;

  for (genvar i = 0; i < LANES; i++) begin : g_lane
    localparam logic [ADDR_W-1:0] MY_ADDR = ADDR_W'(BASE_ADDR + SLR_ADDR_STEP * i);
    lane_op_e op;

    assign hit[i]    = (bus_addr == MY_ADDR);
    assign rd_sel[i] = hit[i] & bus_rd & ~bus_wr;

    always_comb begin
      if (hit[i] && bus_wr)   op = LANE_CAP;
      else if (rd_sel[i])     op = LANE_ADV;
      else                    op = LANE_IDLE;
    end

    slr_lane #(.WORD_W(WORD_W)) u_lane (
      .clk    (clk),
      .rst    (rst),
      .op     (op),
      .par_in (par_in[i]),
      .bit_o  (lane_bit[i])
    );
  end

  slr_rdmux #(.LANES(LANES), .DATA_W(DATA_W)) u_rdmux (
    .clk      (clk),
    .rst      (rst),
    .rd_any   (bus_rd),
    .rd_sel   (rd_sel),
    .lane_bit (lane_bit),
    .rdata    (bus_rdata),
    .rvalid   (bus_rvalid)
  );

  assert_rvalid_pulse_R4: assert property (@(posedge clk) disable iff (rst)
    !bus_rd |=> !bus_rvalid);
  assert_wr_wins_R8: assert property (@(posedge clk) disable iff (rst)
    (bus_rd && bus_wr) |=> (bus_rdata == '0));
endmodule

// File: tb/serial_latch_reader_test.sv
module serial_latch_reader_test;
  localparam int W = 12;
  localparam logic [7:0] A0 = 8'h04;
  localparam logic [7:0] A1 = 8'h06;

  logic        clk = 0;
  logic        rst = 1;
  logic [7:0]  bus_addr = '0;
  logic        bus_wr = 0, bus_rd = 0;
  logic [15:0] bus_wdata = '0;
  logic [11:0] in_word0 = '0, in_word1 = '0;
  logic [15:0] bus_rdata;
  logic        bus_rvalid;

  int tests = 0, fails = 0;
  logic [11:0] m_sh [2];
  int          m_left [2];

  always #5 clk = ~clk;

  serial_latch_reader uut (
    .clk(clk), .rst(rst), .bus_addr(bus_addr), .bus_wr(bus_wr), .bus_rd(bus_rd),
    .bus_wdata(bus_wdata), .in_word0(in_word0), .in_word1(in_word1),
    .bus_rdata(bus_rdata), .bus_rvalid(bus_rvalid));

  function automatic int lane_of(logic [7:0] a);
    if (a == A0) return 0;
    if (a == A1) return 1;
    return -1;
  endfunction

  function automatic logic model_bit(int l);
    if (l < 0 || m_left[l] == 0) return 1'b0;
    return m_sh[l][W-1];
  endfunction

  task automatic check(string req, logic [31:0] act, logic [31:0] exp);
    tests++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic do_op(logic [7:0] a, logic wr, logic rd, string req);
    int l;
    logic expb;
    l = lane_of(a);
    bus_addr = a; bus_wr = wr; bus_rd = rd; bus_wdata = 16'($urandom);
    expb = (rd && !wr) ? model_bit(l) : 1'b0;
    @(posedge clk);
    if (l >= 0) begin
      if (wr) begin
        m_sh[l] = (l == 0) ? in_word0 : in_word1;
        m_left[l] = W;
      end else if (rd && m_left[l] > 0) begin
        m_sh[l] = m_sh[l] << 1;
        m_left[l]--;
      end
    end
    @(negedge clk);
    bus_wr = 0; bus_rd = 0;
    if (rd) begin
      check(req, {31'd0, bus_rvalid}, 32'd1);
      check(req, {16'd0, bus_rdata}, {31'd0, expb});
    end else begin
      check(req, {31'd0, bus_rvalid}, 32'd0);
    end
  endtask

  initial begin
    #2_000_000;
    fails++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    void'($urandom(32'h5EED));
    m_sh[0] = '0; m_sh[1] = '0; m_left[0] = 0; m_left[1] = 0;
    repeat (3) @(negedge clk);
    rst = 0;
    @(negedge clk);
    // R1 reset state
    check("R1", {16'd0, bus_rdata}, 32'd0);
    check("R1", {31'd0, bus_rvalid}, 32'd0);
    do_op(A0, 0, 1, "R1");
    do_op(A1, 0, 1, "R1");
    // R3 R4 R9: directed pattern, input changed after capture
    in_word0 = 12'hA5C;
    do_op(A0, 1, 0, "R3");
    in_word0 = 12'h3F1;
    for (int k = 0; k < W; k++) do_op(A0, 0, 1, "R4_R9");
    // R5: reads past twelfth
    do_op(A0, 0, 1, "R5");
    do_op(A0, 0, 1, "R5");
    // R6: restart mid-sequence
    in_word0 = 12'hFFF;
    do_op(A0, 1, 0, "R6");
    for (int k = 0; k < 5; k++) do_op(A0, 0, 1, "R6");
    in_word0 = 12'h800;
    do_op(A0, 1, 0, "R6");
    do_op(A0, 0, 1, "R6");
    // R7: interleave with latch 1
    in_word1 = 12'h555;
    do_op(A1, 1, 0, "R7");
    do_op(A1, 0, 1, "R7");
    do_op(A0, 0, 1, "R7");
    do_op(A1, 0, 1, "R7");
    // R2: unmapped addresses
    do_op(8'h05, 1, 0, "R2");
    do_op(8'h05, 0, 1, "R2");
    do_op(A1, 0, 1, "R2");
    // R8: simultaneous write and read
    in_word1 = 12'hF00;
    do_op(A1, 1, 1, "R8");
    do_op(A1, 0, 1, "R8");
    // Random mix
    for (int n = 0; n < 4000; n++) begin
      logic [7:0] a;
      int pick, kind;
      in_word0 = 12'($urandom);
      in_word1 = 12'($urandom);
      pick = int'($urandom_range(0, 9));
      a = (pick < 4) ? A0 : (pick < 8) ? A1 : 8'($urandom);
      kind = int'($urandom_range(0, 15));
      if (kind == 0)      do_op(a, 1, 1, "R8");
      else if (kind < 3)  do_op(a, 1, 0, "R3");
      else                do_op(a, 0, 1, "R4");
    end
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule